// File: doc/BRIEF.md
# Prescaled 64-bit Alarm Timer

A general-purpose timer with a 64-bit time base. A programmable prescaler turns the system clock into counting ticks. On each tick the counter steps by one, up or down. A 64-bit comparator watches the counter. When it is armed and the counter equals the alarm value, it raises an alarm. The alarm sets a sticky interrupt status, drives a level interrupt or a one-cycle edge pulse, and can optionally reload the counter from a preset value.

Software reaches the timer through a plain 32-bit word bus. A write strobe with a 4-bit word address and write data updates registers in the same clock edge. Read data is a combinational function of the address. The live counter is never readable directly. A write to a trigger address copies it into a snapshot pair, which software then reads. The alarm arm bit drops by itself when an alarm fires, so every further alarm needs an explicit re-arm.

Top module: `alarm_timer64`

## Requirements
- R1: After reset, the config word (address 0), both snapshot words (addresses 1 and 2) and the interrupt status (address 10, bit 0) read zero, and both interrupt outputs are low.
- R2: While the run bit (config bit 31) is set, the counter changes by one every N clock cycles. The divider field (config bits 28:13) sets N: N equals the field for values 2 to 65535, N is 65536 for a field of 0, and N is 2 for a field of 1. Every write to the config word restarts the prescaler phase. Over E clock edges from the enabling write up to and including the disabling write, the counter moves by floor(E/N).
- R3: Config bit 30 set makes the counter increment and clear makes it decrement, with modulo-2^64 wrap in both directions.
- R4: A write of any data to address 3 copies the live counter into the snapshot, low word at address 1 and high word at address 2. The snapshot does not change otherwise.
- R5: A write of any data to address 8 loads the counter with the preset value held at address 7 (high word) and address 6 (low word).
- R6: When the arm bit (config bit 10) is set and the counter equals the alarm value (address 5 high word, address 4 low word), an alarm fires, the status bit is set and the arm bit reads 0 afterwards. The alarm clear takes precedence over a simultaneous config write.
- R7: With auto-reload (config bit 29) set, an alarm loads the counter from the preset value.
- R8: irq_level is high while status, the interrupt enable (address 9, bit 0) and level enable (config bit 11) are all set. Status holds until a write with bit 0 set to address 11.
- R9: With edge enable (config bit 12) and the interrupt enable set, each alarm gives exactly one irq_edge pulse, one clock cycle wide, in the cycle after the match.
- R10: With the interrupt enable clear, an alarm still sets the status bit but neither output is driven. Setting the enable afterwards raises irq_level for a pending status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for one clock cycle |
| bus_addr | input | 4 | Word address for reads and writes |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq_level | output | 1 | Level interrupt, held while status is pending |
| irq_edge | output | 1 | One-cycle alarm pulse |

## Verification
The counter can only be seen through the snapshot, so a prescaler phase or direction error shows as a wrong count. A stopped counter's count, compared with floor(E/N) steps from a known preset, exposes any such error at the first snapshot after the counting window. A wrong comparator or a missed disarm shows within one cycle as the status bit, the pulse width on irq_edge, or the arm bit read back from the config word. A broken auto-reload shows as a snapshot that is not equal to the preset shortly after the alarm. Ratio corner cases (field 0 and field 1) and the 32-bit carry and borrow across the word boundary each get a directed check.

// File: rtl/atmr_pkg.sv
package atmr_pkg;
   // config word bit positions (software decodes these)
   localparam int CFG_ALARM   = 10;
   localparam int CFG_LEVEL   = 11;
   localparam int CFG_EDGE    = 12;
   localparam int CFG_DIV_LSB = 13;
   localparam int CFG_AUTO    = 29;
   localparam int CFG_UP      = 30;
   localparam int CFG_RUN     = 31;

   localparam int ADDR_W = 4;

   // word addresses
   localparam logic [ADDR_W-1:0] RA_CFG     = 4'd0;
   localparam logic [ADDR_W-1:0] RA_SNAP_LO = 4'd1;
   localparam logic [ADDR_W-1:0] RA_SNAP_HI = 4'd2;
   localparam logic [ADDR_W-1:0] RA_SNAP_GO = 4'd3;
   localparam logic [ADDR_W-1:0] RA_ALM_LO  = 4'd4;
   localparam logic [ADDR_W-1:0] RA_ALM_HI  = 4'd5;
   localparam logic [ADDR_W-1:0] RA_LD_LO   = 4'd6;
   localparam logic [ADDR_W-1:0] RA_LD_HI   = 4'd7;
   localparam logic [ADDR_W-1:0] RA_LD_GO   = 4'd8;
   localparam logic [ADDR_W-1:0] RA_IEN     = 4'd9;
   localparam logic [ADDR_W-1:0] RA_IST     = 4'd10;
   localparam logic [ADDR_W-1:0] RA_ICLR    = 4'd11;
endpackage

// File: rtl/atmr_prescaler.sv
module atmr_prescaler #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] divider,
   output logic             tick
);
   logic [DIV_W-1:0] phase_q;
   logic [DIV_W-1:0] last_phase;

   // ratio minus one: field 0 gives 2^DIV_W, field 1 is raised to 2
   always_comb begin
      if (divider == '0)
         last_phase = '1;
      else if (divider == DIV_W'(1))
         last_phase = DIV_W'(1);
      else
         last_phase = divider - DIV_W'(1);
   end

   assign tick = run && (phase_q == last_phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (restart || tick)
         phase_q <= '0;
      else if (run)
         phase_q <= phase_q + DIV_W'(1);
   end

   // R2: a restarted phase cannot tick on the very next cycle
   assert_restart_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !tick);
endmodule

// File: rtl/atmr_core.sv
module atmr_core #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             count_up,
   input  logic             load_now,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] alarm_val,
   input  logic             armed,
   input  logic             auto_reload,
   output logic [CNT_W-1:0] count,
   output logic             fire
);
   assign fire = armed && (count == alarm_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load_now || (fire && auto_reload))
         count <= load_val;
      else if (tick)
         count <= count_up ? count + CNT_W'(1) : count - CNT_W'(1);
   end

   // R2: no tick and no load leaves the counter alone
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load_now && !(fire && auto_reload)) |=> $stable(count));
   // R3: upward step is exactly one
   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count_up && !load_now && !(fire && auto_reload))
      |=> count == $past(count) + CNT_W'(1));
   // R5: software load takes the preset
   assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_now |=> count == $past(load_val));
endmodule

// File: rtl/atmr_irq.sv
module atmr_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic clear,
   input  logic irq_en,
   input  logic level_en,
   input  logic edge_en,
   output logic status,
   output logic irq_level,
   output logic irq_edge
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= 1'b0;
         irq_edge <= 1'b0;
      end else begin
         if (fire)
            status <= 1'b1;
         else if (clear)
            status <= 1'b0;
         irq_edge <= fire && edge_en && irq_en;
      end
   end

   assign irq_level = status && irq_en && level_en;

   // R8: pending status survives until cleared
   assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !clear) |=> status);
   // R9: edge output is a single-cycle pulse
   assert_edge_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_edge |=> !irq_edge);
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64 import atmr_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 64,
   parameter int DIV_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_level,
   output logic              irq_edge
);
   localparam int WORDS = CNT_W / DATA_W;

   generate
      if (WORDS != 2 || CNT_W != WORDS * DATA_W) begin : g_bad_width
         $error("counter must span exactly two bus words");
      end
      if (CFG_DIV_LSB + DIV_W > CFG_AUTO) begin : g_bad_div
         $error("divider field overlaps control bits");
      end
      if (DATA_W <= CFG_RUN) begin : g_bad_data
         $error("bus word too narrow for config layout");
      end
   endgenerate

   logic [DATA_W-1:0] cfg_q;
   logic [CNT_W-1:0]  alarm_q, load_q, snap_q, cnt;
   logic              ien_q, status, tick, fire;

   wire wr_cfg    = bus_we && (bus_addr == RA_CFG);
   wire wr_snap   = bus_we && (bus_addr == RA_SNAP_GO);
   wire wr_reload = bus_we && (bus_addr == RA_LD_GO);
   wire wr_ien    = bus_we && (bus_addr == RA_IEN);
   wire wr_iclr   = bus_we && (bus_addr == RA_ICLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         ien_q <= 1'b0;
      end else begin
         if (wr_cfg)
            cfg_q <= bus_wdata;
         if (fire)
            cfg_q[CFG_ALARM] <= 1'b0;
         if (wr_ien)
            ien_q <= bus_wdata[0];
      end
   end

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] A_ALM = RA_ALM_LO + ADDR_W'(w);
      localparam logic [ADDR_W-1:0] A_LD  = RA_LD_LO + ADDR_W'(w);
      logic [DATA_W-1:0] alm_r, ld_r, snp_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            alm_r <= '0;
            ld_r  <= '0;
            snp_r <= '0;
         end else begin
            if (bus_we && bus_addr == A_ALM)
               alm_r <= bus_wdata;
            if (bus_we && bus_addr == A_LD)
               ld_r <= bus_wdata;
            if (wr_snap)
               snp_r <= cnt[w*DATA_W +: DATA_W];
         end
      end
      assign alarm_q[w*DATA_W +: DATA_W] = alm_r;
      assign load_q[w*DATA_W +: DATA_W]  = ld_r;
      assign snap_q[w*DATA_W +: DATA_W]  = snp_r;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_CFG:     bus_rdata = cfg_q;
         RA_SNAP_LO: bus_rdata = snap_q[DATA_W-1:0];
         RA_SNAP_HI: bus_rdata = snap_q[CNT_W-1 -: DATA_W];
         RA_ALM_LO:  bus_rdata = alarm_q[DATA_W-1:0];
         RA_ALM_HI:  bus_rdata = alarm_q[CNT_W-1 -: DATA_W];
         RA_LD_LO:   bus_rdata = load_q[DATA_W-1:0];
         RA_LD_HI:   bus_rdata = load_q[CNT_W-1 -: DATA_W];
         RA_IEN:     bus_rdata = {{(DATA_W-1){1'b0}}, ien_q};
         RA_IST:     bus_rdata = {{(DATA_W-1){1'b0}}, status};
         default:    bus_rdata = '0;
      endcase
   end

   atmr_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (cfg_q[CFG_RUN]),
      .restart (wr_cfg),
      .divider (cfg_q[CFG_DIV_LSB +: DIV_W]),
      .tick    (tick)
   );

   atmr_core #(.CNT_W(CNT_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .count_up    (cfg_q[CFG_UP]),
      .load_now    (wr_reload),
      .load_val    (load_q),
      .alarm_val   (alarm_q),
      .armed       (cfg_q[CFG_ALARM]),
      .auto_reload (cfg_q[CFG_AUTO]),
      .count       (cnt),
      .fire        (fire)
   );

   atmr_irq u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .clear     (wr_iclr && bus_wdata[0]),
      .irq_en    (ien_q),
      .level_en  (cfg_q[CFG_LEVEL]),
      .edge_en   (cfg_q[CFG_EDGE]),
      .status    (status),
      .irq_level (irq_level),
      .irq_edge  (irq_edge)
   );

   // R6: the arm bit drops after every alarm, even against a config write
   assert_alarm_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !cfg_q[CFG_ALARM]);
   // R4: snapshot only moves on its trigger
   assert_snapshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_snap |=> $stable(snap_q));
endmodule

// File: tb/tb_alarm_timer64.sv
`timescale 1ns/1ps
module tb_alarm_timer64;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = 4'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        irq_level, irq_edge;

   int total = 0;
   int bad = 0;
   int edge_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   alarm_timer64 dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_level(irq_level), .irq_edge(irq_edge)
   );

   always @(negedge clk) if (irq_edge) edge_cnt++;

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [31:0] cfg(input bit run, input bit up, input bit ar,
      input logic [15:0] div, input bit edg, input bit lvl, input bit alm);
      cfg = {run, up, ar, div, edg, lvl, alm, 10'd0};
   endfunction

   function automatic longint ratio(input logic [15:0] div);
      if (div == 16'd0) ratio = 65536;
      else if (div == 16'd1) ratio = 2;
      else ratio = longint'(div);
   endfunction

   task automatic snap(output logic [63:0] v);
      logic [31:0] lo, hi;
      wr(4'd3, 32'd0);
      rd(4'd1, lo);
      rd(4'd2, hi);
      v = {hi, lo};
   endtask

   task automatic set_count(input logic [63:0] v);
      wr(4'd6, v[31:0]);
      wr(4'd7, v[63:32]);
      wr(4'd8, 32'd0);
   endtask

   // edges from enabling write to disabling write = n + 2
   task automatic run_count(input string tag, input logic [63:0] start, input bit up,
      input logic [15:0] div, input int n);
      logic [63:0] got, exp, steps;
      wr(4'd0, 32'd0);
      set_count(start);
      wr(4'd0, cfg(1, up, 0, div, 0, 0, 0));
      idle(n);
      wr(4'd0, 32'd0);
      snap(got);
      steps = 64'((longint'(n) + 2) / ratio(div));
      exp = up ? start + steps : start - steps;
      check(tag, got, exp);
   endtask

   task automatic wait_level(input int maxc);
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (irq_level) break;
      end
   endtask

   task automatic wait_edge(input int maxc);
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (edge_cnt != 0) break;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [63:0] v, old;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'd0, d);  check("R1 cfg", 64'(d), 64'd0);
      rd(4'd1, d);  check("R1 snap lo", 64'(d), 64'd0);
      rd(4'd2, d);  check("R1 snap hi", 64'(d), 64'd0);
      rd(4'd10, d); check("R1 status", 64'(d), 64'd0);
      check("R1 irq outputs", {62'd0, irq_level, irq_edge}, 64'd0);

      // R2 prescale ratios, R5 reload
      run_count("R2 div 5", 64'd0, 1, 16'd5, 40);
      run_count("R2 div1 means 2", 64'd100, 1, 16'd1, 8);
      run_count("R2 div0 means 65536", 64'd7, 1, 16'd0, 65533);
      run_count("R5 reload start", 64'h0123_4567_89ab_cdef, 1, 16'd3, 0);
      // R3 carry and borrow across words and 64-bit wrap
      run_count("R3 carry", 64'h0000_0000_ffff_fffe, 1, 16'd2, 4);
      run_count("R3 borrow", 64'h0000_0001_0000_0001, 0, 16'd2, 4);
      run_count("R3 down wrap", 64'd5, 0, 16'd2, 18);

      // R4 snapshot is stale until triggered
      snap(old);
      wr(4'd0, cfg(1, 1, 0, 16'd2, 0, 0, 0));
      idle(10);
      rd(4'd1, d);
      check("R4 snapshot stale", 64'(d), 64'(old[31:0]));
      wr(4'd0, 32'd0);

      // R2/R3 constrained random counting
      for (int k = 0; k < 20; k++) begin
         logic [15:0] dv;
         dv = 16'(2 + ($urandom() % 19));
         run_count("R2 R3 random", {$urandom(), $urandom()}, 1'($urandom()), dv,
                   int'($urandom() % 100));
      end

      // R6/R8 level alarm
      wr(4'd9, 32'd1);
      set_count(64'd100);
      wr(4'd4, 32'd103); wr(4'd5, 32'd0);
      wr(4'd0, cfg(1, 1, 0, 16'd2, 0, 1, 1));
      wait_level(100);
      check("R8 level raised", 64'(irq_level), 64'd1);
      rd(4'd0, d);  check("R6 arm cleared", 64'(d[10]), 64'd0);
      rd(4'd10, d); check("R6 status set", 64'(d), 64'd1);
      idle(5);
      check("R8 level held", 64'(irq_level), 64'd1);
      check("R9 no edge when disabled", 64'(edge_cnt), 64'd0);
      wr(4'd0, 32'd0);
      snap(v);
      check("R6 no reload without auto", 64'(v >= 64'd103 && v < 64'd120), 64'd1);
      wr(4'd11, 32'd1);
      check("R8 level cleared", 64'(irq_level), 64'd0);
      rd(4'd10, d); check("R8 status cleared", 64'(d), 64'd0);

      // R7/R9 auto-reload with edge pulse
      set_count(64'h0000_0000_ffff_fffe);
      wr(4'd4, 32'd1); wr(4'd5, 32'd1);
      wr(4'd0, cfg(1, 1, 1, 16'd1000, 1, 0, 1));
      wait_edge(5000);
      wr(4'd0, 32'd0);
      snap(v);
      check("R7 auto reload", v, 64'h0000_0000_ffff_fffe);
      idle(20);
      check("R9 single edge pulse", 64'(edge_cnt), 64'd1);
      check("R8 no level when level off", 64'(irq_level), 64'd0);
      wr(4'd11, 32'd1);

      // R10 enable gating with pending status
      wr(4'd9, 32'd0);
      set_count(64'd7);
      wr(4'd4, 32'd7); wr(4'd5, 32'd0);
      wr(4'd0, cfg(0, 1, 0, 16'd2, 1, 1, 1));
      idle(3);
      check("R10 gated level", 64'(irq_level), 64'd0);
      check("R10 gated edge", 64'(edge_cnt), 64'd1);
      rd(4'd10, d); check("R10 status still set", 64'(d), 64'd1);
      wr(4'd9, 32'd1);
      check("R10 level after enable", 64'(irq_level), 64'd1);
      wr(4'd11, 32'd1);
      check("R8 clear write", 64'(irq_level), 64'd0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule